// File: doc/BRIEF.md
# Chopper Switch-Phase Sequencer

This block turns one fast system clock into the full set of switch-control phases that a chopper-stabilized amplifier needs. A chop period is split into two equal halves. In the first half the main phase `phi1` drives the input voltage switches; in the second half `phi2` does. A few idle cycles at the start of each half keep the two main phases apart. Inside each main phase, a pair of steering outputs of opposite polarity routes the amplifier output current to one branch. These outputs start a guard interval after the main phase rises and end a guard interval before it falls. Whenever no steering pair is on, a pair of crossover outputs sends the current to the supply. The input switches therefore always change over while the current is parked.

Three configuration words set the timing: the half-period length, the non-overlap gap and the inner guard, all counted in system clocks. The block checks each new setting. It adopts a setting only at the start of a new `phi1` half, and only if the guard intervals fit inside the half. An illegal setting is dropped and the timing in use stays as it was. Releasing reset or enable starts a fresh period with the `phi1` half. Dropping enable parks every phase on the next clock. With the default half-period of 1628 clocks at 125 MHz, the chop rate is about 38.4 kHz.

Top module: `chop_phase_gen`

## Requirements
- R1: While reset is low, and on the first clock edge that samples enable low, every output goes to its parked value: `phi1`, `phi2`, `n1` and `n2` are 0, `p1_n` and `p2_n` are 1, `nx` is 1 and `px_n` is 0.
- R2: `phi1` and `phi2` are never 1 in the same cycle. Each falling edge of a main phase is followed by at least one cycle with both main phases at 0.
- R3: With half length H and gap G in effect, the chop period is 2H cycles. Position k of the period (0 to 2H-1) appears one cycle after the corresponding counter state. `phi1` is 1 for k in [G, H) and `phi2` is 1 for k in [H+G, 2H).
- R4: With guard D in effect, `n1` is 1 exactly for k in [G+D, H-D) and `n2` is 1 exactly for k in [H+G+D, 2H-D).
- R5: `p1_n` is the inverse of `n1` and `p2_n` is the inverse of `n2`. Each pair changes on the same clock edge.
- R6: `nx` is 1 and `px_n` is 0 exactly in the cycles when neither `n1` nor `n2` is 1. They are therefore active on every main-phase edge.
- R7: `n1` is 1 only while `phi1` is 1, and `n2` only while `phi2` is 1. A steering output is never 1 in the cycle its main phase rises, nor in the cycle just before the main phase falls.
- R8: New configuration values take effect only at the start of a `phi1` half, either at the period wrap or when the block starts. A change in mid-period leaves the current period unchanged.
- R9: A setting is legal when G >= 1, D >= 1 and G + 2D < H. An illegal setting presented at a period start is rejected, and the setting in use is kept.
- R10: When enable rises, the first clock parks the outputs while the setting is loaded. Position k = 0 of a new period follows, so `phi1` is the first main phase to rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low parks all phases |
| cfg_half | input | CW | Requested half-period length H in clocks |
| cfg_gap | input | CW | Requested non-overlap gap G in clocks |
| cfg_guard | input | CW | Requested inner guard D in clocks |
| phi1 | output | 1 | Main chop phase, first half |
| phi2 | output | 1 | Main chop phase, second half |
| n1 | output | 1 | Steering phase inside phi1, active high |
| p1_n | output | 1 | Steering phase inside phi1, active low |
| n2 | output | 1 | Steering phase inside phi2, active high |
| p2_n | output | 1 | Steering phase inside phi2, active low |
| nx | output | 1 | Crossover phase, active high |
| px_n | output | 1 | Crossover phase, active low |

## Verification
The hardest case to reach is a configuration write that arrives while a period is running. Keeping the old timing in that case is only visible at the exact cycle where one period ends and the next begins. The stimulus changes the setting in the middle of a half. It then compares every output, on every cycle through the next wrap, with a position model held in the bench. Illegal settings are presented in the same way, including one where G + 2D equals H exactly and a legal one just below that limit. This shows that a rejected word leaves the running period and the next one unchanged.

// File: rtl/chop_phase_pkg.sv
package chop_phase_pkg;

  typedef enum logic {
    HALF_A = 1'b0,
    HALF_B = 1'b1
  } half_e;

  typedef struct packed {
    logic main;
    logic steer;
  } lane_t;

  // legal when both guard intervals fit inside one half with room to spare
  function automatic logic cfg_ok(input int unsigned half_len,
                                  input int unsigned gap,
                                  input int unsigned guard);
    return (gap >= 1) && (guard >= 1) && ((gap + 2 * guard) < half_len);
  endfunction

  // main phase window within its own half
  function automatic logic main_on(input int unsigned pos,
                                   input int unsigned gap,
                                   input int unsigned half_len);
    return (pos >= gap) && (pos < half_len);
  endfunction

  // steering window nested inside the main window
  function automatic logic steer_on(input int unsigned pos,
                                    input int unsigned gap,
                                    input int unsigned guard,
                                    input int unsigned half_len);
    return (pos >= gap + guard) && (pos + guard < half_len);
  endfunction

endpackage

// File: rtl/chop_cfg_shadow.sv
module chop_cfg_shadow
  import chop_phase_pkg::*;
#(
  parameter int CW        = 16,
  parameter int DEF_HALF  = 1628,
  parameter int DEF_GAP   = 8,
  parameter int DEF_GUARD = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] req_half,
  input  logic [CW-1:0] req_gap,
  input  logic [CW-1:0] req_guard,
  output logic [CW-1:0] act_half,
  output logic [CW-1:0] act_gap,
  output logic [CW-1:0] act_guard,
  output logic          cand_ok
);

  assign cand_ok = cfg_ok(32'(req_half), 32'(req_gap), 32'(req_guard));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_half  <= CW'(DEF_HALF);
      act_gap   <= CW'(DEF_GAP);
      act_guard <= CW'(DEF_GUARD);
    end else if (load && cand_ok) begin
      act_half  <= req_half;
      act_gap   <= req_gap;
      act_guard <= req_guard;
    end
  end

endmodule

// File: rtl/chop_timebase.sv
module chop_timebase
  import chop_phase_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] half_len,
  output logic [CW-1:0] cnt,
  output half_e         sel,
  output logic          run,
  output logic          half_end,
  output logic          load
);

  assign half_end = (cnt == half_len - CW'(1));
  assign load     = en && (!run || (sel == HALF_B && half_end));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sel <= HALF_A;
      run <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      sel <= HALF_A;
      run <= 1'b0;
    end else if (load) begin
      cnt <= '0;
      sel <= HALF_A;
      run <= 1'b1;
    end else if (half_end) begin
      cnt <= '0;
      sel <= HALF_B;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/chop_lane_decode.sv
module chop_lane_decode
  import chop_phase_pkg::*;
#(
  parameter int CW   = 16,
  parameter int LANE = 0
) (
  input  logic          run,
  input  half_e         sel,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] gap,
  input  logic [CW-1:0] guard,
  input  logic [CW-1:0] half_len,
  output lane_t         lane
);

  localparam half_e MY_SEL = (LANE == 0) ? HALF_A : HALF_B;

  logic mine;
  assign mine = run && (sel == MY_SEL);

  always_comb begin
    lane.main  = mine && main_on(32'(cnt), 32'(gap), 32'(half_len));
    lane.steer = mine && steer_on(32'(cnt), 32'(gap), 32'(guard), 32'(half_len));
  end

endmodule

// File: rtl/chop_phase_gen.sv
module chop_phase_gen
  import chop_phase_pkg::*;
#(
  parameter int CW        = 16,
  parameter int DEF_HALF  = 1628,
  parameter int DEF_GAP   = 8,
  parameter int DEF_GUARD = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] cfg_half,
  input  logic [CW-1:0] cfg_gap,
  input  logic [CW-1:0] cfg_guard,
  output logic          phi1,
  output logic          phi2,
  output logic          n1,
  output logic          p1_n,
  output logic          n2,
  output logic          p2_n,
  output logic          nx,
  output logic          px_n
);

  localparam int NLANE = 2;

  logic [CW-1:0] act_half, act_gap, act_guard;
  logic [CW-1:0] cnt;
  half_e         sel;
  logic          run, half_end, load, cand_ok;
  lane_t         lane_nxt [NLANE];
  lane_t         lane_q   [NLANE];

  chop_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en), .half_len(act_half),
    .cnt(cnt), .sel(sel), .run(run), .half_end(half_end), .load(load)
  );

  chop_cfg_shadow #(
    .CW(CW), .DEF_HALF(DEF_HALF), .DEF_GAP(DEF_GAP), .DEF_GUARD(DEF_GUARD)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .req_half(cfg_half), .req_gap(cfg_gap), .req_guard(cfg_guard),
    .act_half(act_half), .act_gap(act_gap), .act_guard(act_guard),
    .cand_ok(cand_ok)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    chop_lane_decode #(.CW(CW), .LANE(g)) u_dec (
      .run(run), .sel(sel), .cnt(cnt), .gap(act_gap), .guard(act_guard),
      .half_len(act_half), .lane(lane_nxt[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lane_q[g] <= '0;
      else if (!en) lane_q[g] <= '0;
      else          lane_q[g] <= lane_nxt[g];
    end
  end

  assign phi1 = lane_q[0].main;
  assign phi2 = lane_q[1].main;
  assign n1   = lane_q[0].steer;
  assign p1_n = ~lane_q[0].steer;
  assign n2   = lane_q[1].steer;
  assign p2_n = ~lane_q[1].steer;
  assign nx   = ~(lane_q[0].steer | lane_q[1].steer);
  assign px_n = ~nx;

endmodule

// File: rtl/chop_phase_chk.sv
module chop_phase_chk
  import chop_phase_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          phi1,
  input logic          phi2,
  input logic          n1,
  input logic          p1_n,
  input logic          n2,
  input logic          p2_n,
  input logic          nx,
  input logic          px_n,
  input logic          load,
  input logic [CW-1:0] act_half,
  input logic [CW-1:0] act_gap,
  input logic [CW-1:0] act_guard
);

  a_r1_park: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!phi1 && !phi2 && p1_n && p2_n && nx && !px_n));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1 && phi2));

  a_r2_gap_after_phi1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi1) |-> !phi2);

  a_r2_gap_after_phi2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi2) |-> !phi1);

  a_r6_cross_on_edges: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phi1) || $fell(phi1) || $rose(phi2) || $fell(phi2)) |-> (nx && !px_n));

  a_r7_nest1: assert property (@(posedge clk) disable iff (!rst_n)
    n1 |-> phi1);

  a_r7_nest2: assert property (@(posedge clk) disable iff (!rst_n)
    n2 |-> phi2);

  a_r7_rise_guard1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi1) |-> !n1);

  a_r7_rise_guard2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi2) |-> !n2);

  a_r7_fall_guard1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi1) |-> !$past(n1));

  a_r7_fall_guard2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phi2) |-> !$past(n2));

  a_r8_half_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_half) |-> $past(load));

  a_r8_gap_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_gap) |-> $past(load));

  a_r8_guard_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_guard) |-> $past(load));

  a_r9_active_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok(32'(act_half), 32'(act_gap), 32'(act_guard)));

endmodule

bind chop_phase_gen chop_phase_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .phi1(phi1), .phi2(phi2), .n1(n1), .p1_n(p1_n), .n2(n2), .p2_n(p2_n),
  .nx(nx), .px_n(px_n), .load(load),
  .act_half(act_half), .act_gap(act_gap), .act_guard(act_guard)
);

// File: tb/chop_phase_gen_tb.sv
module chop_phase_gen_tb;

  localparam int CW = 16;
  localparam int D_HALF = 1628;
  localparam int D_GAP = 8;
  localparam int D_GUARD = 16;
  localparam int NV = 6;
  // {half, gap, guard}
  localparam logic [47:0] VEC [NV] = '{
    {16'd8,  16'd1, 16'd1},
    {16'd10, 16'd2, 16'd3},
    {16'd12, 16'd3, 16'd1},
    {16'd9,  16'd1, 16'd3},
    {16'd20, 16'd4, 16'd5},
    {16'd6,  16'd1, 16'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [CW-1:0] cfg_half = '0, cfg_gap = '0, cfg_guard = '0;
  logic phi1, phi2, n1, p1_n, n2, p2_n, nx, px_n;

  int checks = 0;
  int errors = 0;
  int midx = -1;
  int m_half = D_HALF, m_gap = D_GAP, m_guard = D_GUARD;

  always #4 clk = ~clk;

  chop_phase_gen #(.CW(CW), .DEF_HALF(D_HALF), .DEF_GAP(D_GAP), .DEF_GUARD(D_GUARD)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_half(cfg_half), .cfg_gap(cfg_gap), .cfg_guard(cfg_guard),
    .phi1(phi1), .phi2(phi2), .n1(n1), .p1_n(p1_n), .n2(n2), .p2_n(p2_n),
    .nx(nx), .px_n(px_n)
  );

  function automatic bit legal(int h, int g, int d);
    return g > 0 && d > 0 && (h - g - d - d) > 0;
  endfunction

  // order: phi1 phi2 n1 p1_n n2 p2_n nx px_n
  function automatic logic [7:0] exp_vec(int idx);
    int lane, pos;
    bit m, s;
    if (idx < 0) return 8'b0001_0110;
    lane = idx / m_half;
    pos = idx % m_half;
    m = pos >= m_gap;
    s = (pos - m_gap) >= m_guard && (m_half - pos) > m_guard;
    return {lane == 0 && m, lane == 1 && m, lane == 0 && s, !(lane == 0 && s),
            lane == 1 && s, !(lane == 1 && s), !s, s};
  endfunction

  task automatic chk(bit ok, string req, string ctx, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s idx=%0d: actual %b expected %b", req, ctx, midx, got, exp);
    end
  endtask

  task automatic adopt();
    if (legal(int'(cfg_half), int'(cfg_gap), int'(cfg_guard))) begin
      m_half = int'(cfg_half);
      m_gap = int'(cfg_gap);
      m_guard = int'(cfg_guard);
    end
  endtask

  task automatic step(string ctx);
    logic [7:0] got, exp;
    @(posedge clk);
    @(negedge clk);
    got = {phi1, phi2, n1, p1_n, n2, p2_n, nx, px_n};
    exp = exp_vec(midx);
    if (midx < 0) begin
      chk(got == exp, "R1", ctx, got, exp);
    end else begin
      chk(got[7:6] == exp[7:6], "R3", ctx, got, exp);
      chk(got[5] == exp[5] && got[3] == exp[3], "R4", ctx, got, exp);
      chk(got[4] == exp[4] && got[2] == exp[2], "R5", ctx, got, exp);
      chk(got[1:0] == exp[1:0], "R6", ctx, got, exp);
      chk(!(got[7] && got[6]), "R2", ctx, got, 8'b0);
    end
    if (rst_n && en) begin
      if (midx < 0) begin
        midx = 0;
        adopt();
      end else begin
        midx++;
        if (midx == 2 * m_half) begin
          midx = 0;
          adopt();
        end
      end
    end
  endtask

  task automatic set_cfg(int h, int g, int d);
    cfg_half = CW'(h);
    cfg_gap = CW'(g);
    cfg_guard = CW'(d);
  endtask

  task automatic run_to_mid(string ctx);
    do step(ctx); while (midx != m_half / 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    for (int i = 0; i < 3; i++) step("reset R1");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step("idle R1");

    // vector table: R3 R4 R5 R6 across settings
    for (int v = 0; v < NV; v++) begin
      set_cfg(int'(VEC[v][47:32]), int'(VEC[v][31:16]), int'(VEC[v][15:0]));
      en = 1'b1;
      for (int i = 0; i < 4 * int'(VEC[v][47:32]) + 3; i++) step("table");
      en = 1'b0;
      midx = -1;
      step("disable R10");
    end

    // R8 mid-period change waits for the next phi1 half
    set_cfg(10, 2, 2);
    en = 1'b1;
    step("r8 start");
    run_to_mid("r8 pre");
    set_cfg(14, 3, 2);
    for (int i = 0; i < 60; i++) step("r8 change");

    // R9 illegal settings are ignored
    run_to_mid("r9 pre");
    set_cfg(14, 0, 2);
    for (int i = 0; i < 30; i++) step("r9 gap zero");
    run_to_mid("r9 pre");
    set_cfg(14, 3, 0);
    for (int i = 0; i < 30; i++) step("r9 guard zero");
    run_to_mid("r9 pre");
    set_cfg(8, 2, 3);
    for (int i = 0; i < 30; i++) step("r9 exact limit");
    chk(m_half == 14, "R9", "model kept", 8'(m_half), 8'd14);
    run_to_mid("r9 pre");
    set_cfg(9, 2, 3);
    for (int i = 0; i < 40; i++) step("r9 just legal");
    chk(m_half == 9, "R9", "legal adopted", 8'(m_half), 8'd9);

    // R10 disable mid-run, re-enable starts with phi1
    run_to_mid("r10 pre");
    en = 1'b0;
    midx = -1;
    step("r10 park");
    step("r10 park");
    en = 1'b1;
    step("r10 load");
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 40 && !seen; i++) begin
        step("r10 restart");
        if (phi1 || phi2) begin
          seen = 1'b1;
          chk(phi1 && !phi2, "R10", "first main phase", {phi1, phi2, 6'b0}, 8'b1000_0000);
        end
      end
      chk(seen, "R10", "main phase rose", {7'b0, seen}, 8'd1);
    end

    // R1 reset while running
    run_to_mid("r1 pre");
    rst_n = 1'b0;
    en = 1'b0;
    midx = -1;
    m_half = D_HALF;
    m_gap = D_GAP;
    m_guard = D_GUARD;
    step("r1 mid reset");
    step("r1 mid reset");
    rst_n = 1'b1;
    step("r1 after");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule